// File: doc/BRIEF.md
# Channel Context Double-Buffer with Handshaked Reload

This block holds the context of one transfer channel in two register sets. Software writes a configuration set through a simple register write port; a working set, copied from it in one clock, is what the transfer engine consumes. The copy happens when software starts an idle channel. When automatic reload is on, the copy also happens at the end of each block.

For automatic reload, the reload is either unconditional or gated by an end-of-programming flag. With the gated form, software reprograms the configuration set while the current block runs and then sets the flag. At block end the block copies the new context, clears the flag and re-enables the channel. If the flag is not yet set at block end, the channel stalls with enable low and a waiting flag high until software sets it. Block completion arrives as a one-cycle pulse from the transfer engine. Address generation and data movement live elsewhere.

Top module: `ctx_reload_ctrl`

## Requirements
- R1: After reset, channel enable, end-of-programming flag and waiting flag are 0 and the working context is all zeros.
- R2: The register map is control at address 0, source address at 1, destination address at 2, element count at 3 and frame count at 4. The control bits are enable = bit 0, automatic reload = bit 8, repeat = bit 9 and end-of-programming = bit 11. The working context is packed as {source, destination, element count, frame count}, with source in the most significant bits.
- R3: A control write with bit 0 set, while the channel is neither enabled nor waiting, copies the configuration set into the working context and raises enable one cycle after the write.
- R4: Writes to the configuration set while the channel is enabled leave the working context unchanged until the next copy.
- R5: A block-done pulse with automatic reload off clears enable, and the working context keeps its value.
- R6: With automatic reload and repeat both 1, a block-done pulse copies the configuration set and enable stays 1, whatever the end-of-programming flag holds.
- R7: With automatic reload 1 and repeat 0, a block-done pulse while end-of-programming is 0 clears enable and raises the waiting flag with no copy. A later control write that sets end-of-programming (with bit 0 kept at 1) copies, re-enables and clears the waiting flag.
- R8: Every copy leaves the end-of-programming flag at 0.
- R9: When a control write that sets end-of-programming and a block-done pulse land in the same cycle, the copy happens and the flag ends at 0.
- R10: A control write with bit 0 clear stops the channel at once. It clears enable and the waiting flag and copies nothing.
- R11: Clearing automatic reload during a block lets that block end normally. At its block-done pulse, enable drops with no reload and no waiting.
- R12: A block-done pulse while the channel is disabled has no effect on enable, the waiting flag or the working context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | ADDR_W | Register write data |
| blk_done_i | input | 1 | One-cycle block completion pulse from the transfer engine |
| ch_en_o | output | 1 | Channel enable |
| work_ctx_o | output | 2*ADDR_W+2*CNT_W | Working context {src, dst, elem, frame} |
| ep_o | output | 1 | End-of-programming flag |
| wait_o | output | 1 | Stalled at block end waiting for end-of-programming |

## Verification
The bench drives block-done pulses under four reload settings: reload off, unconditional repeat, gated repeat with the flag set beforehand, and gated repeat with the flag set late. Each setting is told apart by whether enable drops, whether the waiting flag rises and whether the working context takes the newly written source address. Collision and abort patterns are also applied: a flag write coinciding with block end, a stop write issued while waiting, a reload-bit clear during a block, and a done pulse with the channel disabled. Each of these is distinguished by checking that stale context is kept and that the flag ends in the required state.

// File: rtl/ctx_reload_pkg.sv
package ctx_reload_pkg;
  typedef enum logic [2:0] {
    RA_CTRL  = 3'd0,
    RA_SRC   = 3'd1,
    RA_DST   = 3'd2,
    RA_ELEM  = 3'd3,
    RA_FRAME = 3'd4
  } reg_addr_e;

  localparam int unsigned BIT_EN   = 0;
  localparam int unsigned BIT_AUTO = 8;
  localparam int unsigned BIT_RPT  = 9;
  localparam int unsigned BIT_EP   = 11;
  localparam int unsigned N_FLD    = 4;
endpackage

// File: rtl/ctx_cfg_regs.sv
module ctx_cfg_regs
  import ctx_reload_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned CNT_W  = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [2:0]                    wr_addr_i,
  input  logic [ADDR_W-1:0]             wr_data_i,
  output logic [2*ADDR_W+2*CNT_W-1:0]   cfg_d_o
);
  // field k: 0 frame, 1 elem, 2 dst, 3 src; address = 4 - k
  for (genvar k = 0; k < N_FLD; k++) begin : g_fld
    localparam int unsigned W  = (k < 2) ? CNT_W : ADDR_W;
    localparam int unsigned LO = (k == 0) ? 0 :
                                 (k == 1) ? CNT_W :
                                 (k == 2) ? 2*CNT_W : 2*CNT_W + ADDR_W;
    localparam logic [2:0] FA  = 3'(4 - k);
    logic [W-1:0] q;
    logic         hit;
    assign hit = wr_en_i && (wr_addr_i == FA);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q <= '0;
      else if (hit) q <= wr_data_i[W-1:0];
    end
    // software write is seen by a copy in the same cycle
    assign cfg_d_o[LO +: W] = hit ? wr_data_i[W-1:0] : q;
  end
endmodule

// File: rtl/ctx_reload_fsm.sv
module ctx_reload_fsm
  import ctx_reload_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [2:0] wr_addr_i,
  input  logic [3:0] ctl_bits_i,  // {ep, rpt, auto, en}
  input  logic       blk_done_i,
  output logic       en_o,
  output logic       ep_o,
  output logic       wait_o,
  output logic       copy_o
);
  logic en_q, ep_q, wait_q, auto_q, rpt_q;
  logic ctl_wr, stop, done, pend, reload, load, copy;
  logic auto_n, rpt_n, ep_n, en_d, ep_d, wait_d;

  assign ctl_wr = wr_en_i && (wr_addr_i == RA_CTRL);
  assign auto_n = ctl_wr ? ctl_bits_i[1] : auto_q;
  assign rpt_n  = ctl_wr ? ctl_bits_i[2] : rpt_q;
  assign ep_n   = ctl_wr ? ctl_bits_i[3] : ep_q;
  assign stop   = ctl_wr && !ctl_bits_i[0];
  assign done   = blk_done_i && en_q;
  assign pend   = done || wait_q;
  assign reload = !stop && pend && auto_n && (rpt_n || ep_n);
  assign load   = ctl_wr && ctl_bits_i[0] && !en_q && !wait_q;
  assign copy   = reload || load;
  assign wait_d = !stop && pend && auto_n && !reload;
  assign ep_d   = copy ? 1'b0 : ep_n;

  always_comb begin
    en_d = en_q;
    if (copy)              en_d = 1'b1;
    else if (stop || done) en_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; ep_q <= 1'b0; wait_q <= 1'b0; auto_q <= 1'b0; rpt_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      ep_q   <= ep_d;
      wait_q <= wait_d;
      auto_q <= auto_n;
      rpt_q  <= rpt_n;
    end
  end

  assign en_o   = en_q;
  assign ep_o   = ep_q;
  assign wait_o = wait_q;
  assign copy_o = copy;

  p_wait_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_q |-> !en_q);
  p_rise_ep_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_q) |-> !ep_q);
  p_done_noauto_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_done_i && en_q && !auto_q && !ctl_wr) |=> !en_q);
  p_repeat_runs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_done_i && en_q && auto_q && rpt_q && !ctl_wr) |=> (en_q && !wait_q));
  p_stop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr && !ctl_bits_i[0]) |=> (!en_q && !wait_q));
endmodule

// File: rtl/ctx_work_regs.sv
module ctx_work_regs #(
  parameter int unsigned CTX_W = 80
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             copy_i,
  input  logic [CTX_W-1:0] cfg_d_i,
  output logic [CTX_W-1:0] work_o
);
  logic [CTX_W-1:0] work_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     work_q <= '0;
    else if (copy_i) work_q <= cfg_d_i;
  end
  assign work_o = work_q;

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !copy_i |=> $stable(work_q));
endmodule

// File: rtl/ctx_reload_ctrl.sv
module ctx_reload_ctrl
  import ctx_reload_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned CNT_W  = 16,
  localparam int unsigned CTX_W = 2*ADDR_W + 2*CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic              blk_done_i,
  output logic              ch_en_o,
  output logic [CTX_W-1:0]  work_ctx_o,
  output logic              ep_o,
  output logic              wait_o
);
  logic [CTX_W-1:0] cfg_d;
  logic [3:0]       ctl_bits;
  logic             copy;

  assign ctl_bits = {wr_data_i[BIT_EP], wr_data_i[BIT_RPT],
                     wr_data_i[BIT_AUTO], wr_data_i[BIT_EN]};

  ctx_cfg_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .cfg_d_o(cfg_d));

  ctx_reload_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .ctl_bits_i(ctl_bits), .blk_done_i(blk_done_i),
    .en_o(ch_en_o), .ep_o(ep_o), .wait_o(wait_o), .copy_o(copy));

  ctx_work_regs #(.CTX_W(CTX_W)) u_work (
    .clk_i(clk_i), .rst_ni(rst_ni), .copy_i(copy),
    .cfg_d_i(cfg_d), .work_o(work_ctx_o));

  p_disabled_done_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_done_i && !ch_en_o && !wait_o && !wr_en_i) |=> (!ch_en_o && $stable(work_ctx_o)));
endmodule

// File: tb/sim_ctx_reload_ctrl.sv
module sim_ctx_reload_ctrl;
  localparam int PERIOD = 10;
  localparam int AW = 24;
  localparam int CW = 16;
  localparam int XW = 2*AW + 2*CW;

  logic clk = 0, rst_n = 0, wr_en = 0, done = 0;
  logic [2:0] wr_addr = '0;
  logic [AW-1:0] wr_data = '0;
  logic ch_en, ep, wt;
  logic [XW-1:0] work;
  int total = 0, bad = 0;
  logic [AW-1:0] e_src, e_dst;
  logic [CW-1:0] e_elem, e_frm;

  always #(PERIOD/2) clk = ~clk;

  ctx_reload_ctrl #(.ADDR_W(AW), .CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .blk_done_i(done), .ch_en_o(ch_en),
    .work_ctx_o(work), .ep_o(ep), .wait_o(wt));

  function automatic logic [XW-1:0] ctx(input logic [AW-1:0] s, d, input logic [CW-1:0] e, f);
    return {s, d, e, f};
  endfunction

  task automatic chk(input string tag, input logic [XW-1:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [AW-1:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse;
    done = 1;
    @(negedge clk);
    done = 0;
  endtask

  task automatic t_reset;
    chk("R1 en", XW'(ch_en), '0);
    chk("R1 ep", XW'(ep), '0);
    chk("R1 wait", XW'(wt), '0);
    chk("R1 work", work, '0);
  endtask

  task automatic t_load;
    e_src = 24'h111111; e_dst = 24'h222222; e_elem = 16'h0010; e_frm = 16'h0003;
    wr(3'd1, e_src); wr(3'd2, e_dst); wr(3'd3, 24'(e_elem)); wr(3'd4, 24'(e_frm));
    chk("R2 no copy before enable", work, '0);
    wr(3'd0, 24'h000001);
    chk("R3 en", XW'(ch_en), 1);
    chk("R2 R3 work layout", work, ctx(e_src, e_dst, e_elem, e_frm));
  endtask

  task automatic t_shadow_noauto;
    wr(3'd1, 24'hAAAAAA);
    chk("R4 work held", work, ctx(e_src, e_dst, e_elem, e_frm));
    pulse();
    chk("R5 en cleared", XW'(ch_en), 0);
    chk("R5 work kept", work, ctx(e_src, e_dst, e_elem, e_frm));
    pulse();
    chk("R12 en", XW'(ch_en), 0);
    chk("R12 wait", XW'(wt), 0);
    chk("R12 work", work, ctx(e_src, e_dst, e_elem, e_frm));
  endtask

  task automatic t_repeat;
    wr(3'd0, 24'h000301);
    e_src = 24'hAAAAAA;
    chk("R6 load", work, ctx(e_src, e_dst, e_elem, e_frm));
    wr(3'd1, 24'hBBBBBB);
    wr(3'd0, 24'h000B01);
    chk("R6 ep set", XW'(ep), 1);
    pulse();
    e_src = 24'hBBBBBB;
    chk("R6 en stays", XW'(ch_en), 1);
    chk("R6 reload", work, ctx(e_src, e_dst, e_elem, e_frm));
    chk("R8 ep cleared", XW'(ep), 0);
    wr(3'd1, 24'h123456);
    pulse();
    e_src = 24'h123456;
    chk("R6 reload ep0", work, ctx(e_src, e_dst, e_elem, e_frm));
    chk("R6 no wait", XW'(wt), 0);
  endtask

  task automatic t_handshake;
    wr(3'd0, 24'h000000);
    chk("R10 stop", XW'(ch_en), 0);
    wr(3'd0, 24'h000101);
    wr(3'd1, 24'hCCCCCC);
    pulse();
    chk("R7 en low", XW'(ch_en), 0);
    chk("R7 wait", XW'(wt), 1);
    chk("R7 no copy", work, ctx(e_src, e_dst, e_elem, e_frm));
    repeat (3) @(negedge clk);
    chk("R7 still wait", XW'(wt), 1);
    wr(3'd0, 24'h000901);
    e_src = 24'hCCCCCC;
    chk("R7 en back", XW'(ch_en), 1);
    chk("R7 wait low", XW'(wt), 0);
    chk("R7 copy", work, ctx(e_src, e_dst, e_elem, e_frm));
    chk("R8 ep cleared", XW'(ep), 0);
  endtask

  task automatic t_collide;
    wr(3'd1, 24'hDDDDDD);
    wr_en = 1; wr_addr = 3'd0; wr_data = 24'h000901; done = 1;
    @(negedge clk);
    wr_en = 0; done = 0;
    e_src = 24'hDDDDDD;
    chk("R9 en", XW'(ch_en), 1);
    chk("R9 ep", XW'(ep), 0);
    chk("R9 wait", XW'(wt), 0);
    chk("R9 copy", work, ctx(e_src, e_dst, e_elem, e_frm));
  endtask

  task automatic t_stop_wait;
    wr(3'd1, 24'hEEEEEE);
    pulse();
    chk("R7 wait again", XW'(wt), 1);
    wr(3'd0, 24'h000800);
    chk("R10 en", XW'(ch_en), 0);
    chk("R10 wait", XW'(wt), 0);
    chk("R10 no copy", work, ctx(e_src, e_dst, e_elem, e_frm));
    pulse();
    chk("R12 after stop", work, ctx(e_src, e_dst, e_elem, e_frm));
  endtask

  task automatic t_auto_clear;
    wr(3'd0, 24'h000101);
    e_src = 24'hEEEEEE;
    chk("R3 reload start", work, ctx(e_src, e_dst, e_elem, e_frm));
    chk("R8 ep after load", XW'(ep), 0);
    wr(3'd1, 24'h777777);
    wr(3'd0, 24'h000001);
    chk("R11 still running", XW'(ch_en), 1);
    pulse();
    chk("R11 en", XW'(ch_en), 0);
    chk("R11 wait", XW'(wt), 0);
    chk("R11 no reload", work, ctx(e_src, e_dst, e_elem, e_frm));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_load();
    t_shadow_noauto();
    t_repeat();
    t_handshake();
    t_collide();
    t_stop_wait();
    t_auto_clear();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule